// File: doc/BRIEF.md
# Sequential Channel Selector for a Time-Division Switch Array

This block steps through eight channels in a fixed rotation and tells a bank of analog switches, one set per channel, which ones to close. A three-bit state counter advances on every rising clock edge. The channel chosen by the counter gets a series-close strobe that joins it to a common serial line. That strobe lasts only for the high half of the clock. The remaining channels can be clamped to a second, parallel line through their shunt-close controls.

Two enables shape the pattern. The matrix enable lets the decode reach the series controls at all, so that several copies of the block can take turns on one serial line. A 32-channel frame, for example, uses four copies whose matrix enables are active one after another for eight clock periods each. The shunt enable chooses what the unselected channels do: left floating, or clamped. A terminal-count output marks the last state of the rotation. An external group counter can use it to rotate the matrix enables of cascaded copies.

Top module: `chan_seq_top`

## Requirements
- R1: The state counter advances by one on every rising clock edge and wraps from 7 to 0. State k selects channel k+1, which is bit k of both control vectors (bit 0 is channel 1).
- R2: The reset input is synchronous and active high. While it is sampled high, the state is 0. Counting resumes on the first rising edge after reset is released, so the state after that edge is 1.
- R3: With `mtx_en`=1, `ser_close` holds bit k alone while `clk` is high in state k. It is all zero while `clk` is low.
- R4: With `mtx_en`=0, `ser_close` is all zero whatever the state and clock phase.
- R5: With `shunt_en`=0, `par_close` is all zero, so every channel without a series closure floats.
- R6: With `shunt_en`=1 and `mtx_en`=0, `par_close` is all ones.
- R7: With `shunt_en`=1 and `mtx_en`=1, `par_close` is the complement of the one-hot selection in both clock phases.
- R8: `last_state` is 1 exactly while the state is 7.
- R9: No bit is set in both `ser_close` and `par_close` at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its high half also times the series strobe |
| rst | input | 1 | Synchronous active-high reset of the state counter |
| mtx_en | input | 1 | Lets the channel decode drive the series controls |
| shunt_en | input | 1 | Lets shunt controls close on unselected channels |
| ser_close | output | 8 | Per-channel series-close strobe, bit 0 = channel 1 |
| par_close | output | 8 | Per-channel shunt-close control, bit 0 = channel 1 |
| last_state | output | 1 | High while the counter is in its final state |

## Verification
The bench uses the default of eight channels. With that setting, the wrap from state 7 to 0 and the terminal-count flag come up every eight clocks, so a short vector table goes through several full rotations under all four enable combinations. Every step is checked in both clock phases. This covers the half-period shape of the series strobe and the non-overlap of series and shunt controls at each phase. Reset is then tested on its own: asserted in the middle of a rotation, held for several clocks, and released, to confirm that counting resumes from state 1.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;

    typedef enum logic [1:0] {
        SHUNT_OPEN       = 2'd0,
        SHUNT_ALL        = 2'd1,
        SHUNT_UNSELECTED = 2'd2
    } shunt_mode_e;

    function automatic shunt_mode_e pick_shunt_mode(input logic shunt_on,
                                                    input logic matrix_on);
        if (!shunt_on)
            return SHUNT_OPEN;
        else if (!matrix_on)
            return SHUNT_ALL;
        else
            return SHUNT_UNSELECTED;
    endfunction

endpackage

// File: rtl/chan_seq_counter.sv
module chan_seq_counter #(
    parameter int N_CH  = 8,
    parameter int CNT_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] state,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_CH - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst)
            st_d.cnt = '0;
        else if (st_q.cnt == LAST)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign state   = st_q.cnt;
    assign at_last = (st_q.cnt == LAST);

    // R1: single-step advance outside the wrap point
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != LAST) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R1: wrap from the last state back to zero
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == LAST) |=> (st_q.cnt == '0));

    // R2: a sampled reset leaves the counter at zero
    a_r2_reset_zero: assert property (@(posedge clk)
        rst |=> (st_q.cnt == '0));

endmodule

// File: rtl/chan_seq_decode.sv
module chan_seq_decode #(
    parameter int N_CH  = 8,
    parameter int CNT_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [CNT_W-1:0] state,
    output logic [N_CH-1:0]  sel
);
    for (genvar g = 0; g < N_CH; g++) begin : g_dec
        assign sel[g] = (state == CNT_W'(g));
    end

    // R1: exactly one channel chosen in every state
    always_comb begin
        a_r1_onehot: assert ($countones(sel) == 1 || $isunknown(state));
    end

endmodule

// File: rtl/chan_seq_switch.sv
module chan_seq_switch
    import chan_seq_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            mtx_en,
    input  logic            shunt_en,
    input  logic [N_CH-1:0] sel,
    output logic [N_CH-1:0] ser_close,
    output logic [N_CH-1:0] par_close
);
    shunt_mode_e mode;

    always_comb begin
        mode      = pick_shunt_mode(shunt_en, mtx_en);
        ser_close = sel & {N_CH{clk & mtx_en}};
        case (mode)
            SHUNT_ALL:        par_close = '1;
            SHUNT_UNSELECTED: par_close = ~sel;
            default:          par_close = '0;
        endcase
    end

    // R9: series and shunt never close together on one channel
    always_comb begin
        a_r9_no_overlap: assert ((ser_close & par_close) == '0);
    end

    // R4: no series closure without matrix enable
    always_comb begin
        a_r4_matrix_gate: assert (mtx_en || ser_close == '0);
    end

    // R5: shunt disabled leaves every shunt open
    always_comb begin
        a_r5_float: assert (shunt_en || par_close == '0);
    end

    // R3: at most one strobe, never during the low half
    always_comb begin
        a_r3_strobe_shape: assert ($onehot0(ser_close) && (clk || ser_close == '0));
    end

endmodule

// File: rtl/chan_seq_top.sv
module chan_seq_top #(
    parameter int N_CH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mtx_en,
    input  logic       shunt_en,
    output logic [7:0] ser_close,
    output logic [7:0] par_close,
    output logic       last_state
);
    localparam int CNT_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [CNT_W-1:0] state;
    logic [N_CH-1:0]  sel;
    logic [N_CH-1:0]  ser_w, par_w;

    chan_seq_counter #(.N_CH(N_CH), .CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .at_last (last_state)
    );

    chan_seq_decode #(.N_CH(N_CH), .CNT_W(CNT_W)) u_decode (
        .state (state),
        .sel   (sel)
    );

    chan_seq_switch #(.N_CH(N_CH)) u_switch (
        .clk       (clk),
        .mtx_en    (mtx_en),
        .shunt_en  (shunt_en),
        .sel       (sel),
        .ser_close (ser_w),
        .par_close (par_w)
    );

    assign ser_close = ser_w[7:0];
    assign par_close = par_w[7:0];

    // R8: terminal flag is followed by state zero unless reset intervenes
    a_r8_last_then_wrap: assert property (@(posedge clk) disable iff (rst)
        last_state |=> !last_state);

endmodule

// File: tb/test_chan_seq_top.sv
module test_chan_seq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mtx_en = 1'b0;
    logic       shunt_en = 1'b0;
    logic [7:0] ser_close, par_close;
    logic       last_state;

    int total = 0;
    int bad = 0;
    int exp_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    chan_seq_top i_chan_seq_top (
        .clk        (clk),
        .rst        (rst),
        .mtx_en     (mtx_en),
        .shunt_en   (shunt_en),
        .ser_close  (ser_close),
        .par_close  (par_close),
        .last_state (last_state)
    );

    // row = {rst, mtx_en, shunt_en}
    localparam logic [2:0] VEC [24] = '{
        3'b100, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011,
        3'b011, 3'b010, 3'b010, 3'b001, 3'b001, 3'b000, 3'b000, 3'b011,
        3'b001, 3'b010, 3'b011, 3'b000, 3'b011, 3'b011, 3'b001, 3'b011
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (state %0d)", tag, act, exp, exp_cnt);
        end
    endtask

    task automatic check_phase(input bit high_phase);
        logic [7:0] sel, e_ser, e_par;
        sel   = 8'(1) << exp_cnt;
        e_ser = (high_phase && mtx_en) ? sel : 8'h00;
        if (!shunt_en)    e_par = 8'h00;
        else if (!mtx_en) e_par = 8'hff;
        else              e_par = ~sel;
        check(mtx_en ? "R3 ser_close" : "R4 ser_close", 32'(ser_close), 32'(e_ser));
        check(!shunt_en ? "R5 par_close" : (mtx_en ? "R7 par_close" : "R6 par_close"),
              32'(par_close), 32'(e_par));
        check("R8 last_state", 32'(last_state), 32'(exp_cnt == 7));
        check("R9 overlap", 32'(ser_close & par_close), 32'h0);
    endtask

    // inputs change just after a falling edge; both phases are then checked
    task automatic step(input logic r, input logic m, input logic s);
        rst = r; mtx_en = m; shunt_en = s;
        @(posedge clk);
        exp_cnt = r ? 0 : (exp_cnt + 1) % 8;
        #1 check_phase(1'b1);
        @(negedge clk);
        #1 check_phase(1'b0);
    endtask

    initial begin
        #1;
        // R2: reset state, ser strobe idle, state 0
        step(1'b1, 1'b0, 1'b0);
        check("R2 reset state last", 32'(last_state), 32'h0);
        foreach (VEC[i]) step(VEC[i][2], VEC[i][1], VEC[i][0]);
        // R1: full rotation with both enables, wrap 7->0 observed
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'b1);
        // R2: reset in mid rotation, held three clocks
        step(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b1, 1'b1);
            check("R2 held at zero", 32'(ser_close | 8'h00), 32'h0);
        end
        // R2: first edge after release gives state 1
        step(1'b0, 1'b1, 1'b0);
        check("R2 resume state1 par", 32'(exp_cnt), 32'd1);
        // R8: cascade timing, last_state every eighth clock
        begin
            int seen = 0;
            for (int k = 0; k < 16; k++) begin
                step(1'b0, 1'b0, 1'b1);
                if (last_state) seen++;
            end
            check("R8 terminal count per 16 clocks", 32'(seen), 32'd2);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule